// File: doc/BRIEF.md
# Single-Bin Sliding DFT Sample-Continuity Monitor

This block watches a stream of signed converter samples that carry a test sine at exactly 1/N of the sample rate. It mixes every accepted sample with a stored complex exponential at that same frequency. It then keeps running sums of the in-phase and quadrature products over the most recent N samples, which is one tone period. This is a single frequency bin of a short-time transform that moves forward one sample at a time. The sum nulls the tone's image at twice the frequency and every other harmonic. The result is therefore a complex value that holds still for a clean tone, or turns slowly if the source and sampler clocks drift.

A lost sample or a repeated sample breaks the phase relation between the stream and the stored exponential. The complex output then steps. The block squares the change between consecutive results and compares it with a programmable limit. When the limit is exceeded, the block emits a one-cycle flag and increments a saturating event counter.

The window length is a power of two, N = 2^k, with k between 2 and a parameter limit (default 6, so N can reach 64). The coefficient table holds one full turn at the maximum length, and shorter windows step through it with a coarser stride. Configuration is held steady and is only changed while reset is low.

Top module: `sdft_glitch_detector`

## Requirements
- R1: The table holds C[k] = round(A·cos(2πk/M)) and S[k] = round(−A·sin(2πk/M)) for M = 2^LOG2_MAX and A = 2^(CW−1)−1. Rounding is to the nearest integer, with halves rounded away from zero. The j-th sample accepted since reset (counting from 0) uses entry k = (j mod N)·(M/N). Its products are x·C[k] (in-phase) and x·S[k] (quadrature).
- R2: The window length is N = 2^cfg_log2n, with cfg_log2n from 2 to LOG2_MAX. It is read continuously and is only changed while rst_n is low.
- R3: One cycle after a cycle with in_valid high, out_valid is high and out_i/out_q hold the sums of the products of the last N accepted samples. Before N samples have been accepted, they hold the sums of all products accepted so far.
- R4: A cycle with in_valid low gives out_valid low in the next cycle. out_i and out_q keep their values, and the coefficient phase does not advance.
- R5: No flag is raised for any of the first N samples accepted after reset.
- R6: Let result r follow result r−1, both covering a full window. The flag is raised for exactly one cycle, the cycle after r's out_valid, if (ΔI)²+(ΔQ)² is strictly greater than cfg_thresh.
- R7: An exact periodic tone at fs/N gives a constant output once the window is full, and never raises the flag, even with cfg_thresh = 0.
- R8: glitch_count increments in the same cycle that glitch is high and holds at all ones once it reaches all ones.
- R9: While rst_n is low at a clock edge, out_valid, glitch, glitch_count, out_i and out_q are all zero after that edge.
- R10: A slow frequency offset below the threshold's reach leaves glitch_count unchanged, while a dropped or repeated sample in the stream raises the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | DW | Signed sample |
| cfg_log2n | input | LW | log2 of the window length N |
| cfg_thresh | input | MW | Limit on squared step magnitude |
| out_valid | output | 1 | Result strobe |
| out_i | output | AW | Signed in-phase window sum |
| out_q | output | AW | Signed quadrature window sum |
| glitch | output | 1 | One-cycle discontinuity flag |
| glitch_count | output | CNT_W | Saturating count of flags |

## Verification
The bench goes after the window fill, where a design that compared partial sums would flag on every start. It tests gaps in in_valid, where a design that advanced the phase or re-summed would report a spurious step. It tests an exact tone with a zero limit, where any coefficient or delay-length mistake shows as a nonzero difference and a false flag. It tests a drifting tone at the largest window, which must stay quiet, and dropped or repeated samples at short windows, which must be caught. Counter saturation is driven with a narrow counter, where a wrap to zero would be visible.

// File: rtl/sdft_pkg.sv
// Shared constants and elaboration-time helpers for the sliding DFT monitor.
// Assumes only constant (elaboration) use of the real-valued helpers.
package sdft_pkg;
    localparam real TWO_PI = 6.283185307179586;

    // Round to the nearest integer, halves away from zero.
    function automatic int round_half_away(input real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        else          return -$rtoi(0.5 - v);
    endfunction
endpackage

// File: rtl/sdft_twiddle.sv
// Coefficient source: one full turn of cosine and negated sine, M entries,
// computed at elaboration. A modulo-M phase advances by M/N per accepted
// sample, so any N = 2^k (k <= LOG2_MAX) lands on exact table points.
// Assumes log2n is held steady outside reset.
module sdft_twiddle #(
    parameter int LOG2_MAX = 6,
    parameter int CW       = 12,
    parameter int LW       = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_en,
    input  logic [LW-1:0]        log2n,
    output logic signed [CW-1:0] coef_c,
    output logic signed [CW-1:0] coef_s
);
    localparam int TAB_N = 1 << LOG2_MAX;
    localparam int AMP   = (1 << (CW - 1)) - 1;

    logic signed [CW-1:0] cos_tab [TAB_N];
    logic signed [CW-1:0] sin_tab [TAB_N];
    logic [LOG2_MAX-1:0]  phase;
    logic [LOG2_MAX-1:0]  stride;

    for (genvar k = 0; k < TAB_N; k++) begin : g_tab
        localparam int CV = sdft_pkg::round_half_away(
            real'(AMP) * $cos(sdft_pkg::TWO_PI * real'(k) / real'(TAB_N)));
        localparam int SV = sdft_pkg::round_half_away(
            -real'(AMP) * $sin(sdft_pkg::TWO_PI * real'(k) / real'(TAB_N)));
        assign cos_tab[k] = CW'(CV);
        assign sin_tab[k] = CW'(SV);
    end

    // Stride through the table: M/N entries per sample.
    assign stride = {{(LOG2_MAX-1){1'b0}}, 1'b1} << (LW'(LOG2_MAX) - log2n);

    // Phase pointer: advances only on accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase <= '0;
        else if (step_en) phase <= phase + stride;
    end

    assign coef_c = cos_tab[phase];
    assign coef_s = sin_tab[phase];
endmodule

// File: rtl/sdft_window.sv
// Mixer and N-long moving sums. Each accepted sample is multiplied by the
// current coefficients. The products go into a circular delay line of M
// entries, and each running sum adds the newest product and removes the
// one N samples old once the window is full. Results are registered.
// Assumes log2n is held steady outside reset.
module sdft_window #(
    parameter int LOG2_MAX = 6,
    parameter int DW       = 12,
    parameter int CW       = 12,
    parameter int LW       = 3,
    localparam int PW      = DW + CW,
    localparam int AW      = PW + LOG2_MAX
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    input  logic signed [CW-1:0] coef_c,
    input  logic signed [CW-1:0] coef_s,
    input  logic [LW-1:0]        log2n,
    output logic signed [AW-1:0] acc_i,
    output logic signed [AW-1:0] acc_q,
    output logic                 out_valid,
    output logic                 out_full
);
    localparam int TAB_N = 1 << LOG2_MAX;

    logic signed [PW-1:0] mem_i [TAB_N];
    logic signed [PW-1:0] mem_q [TAB_N];
    logic signed [PW-1:0] x_ext, c_ext, s_ext, prod_i, prod_q, old_i, old_q;
    logic [LOG2_MAX:0]    n_len, fill;
    logic [LOG2_MAX-1:0]  wp, rp;
    logic                 is_full;

    assign n_len   = (LOG2_MAX+1)'(1) << log2n;
    assign is_full = (fill == n_len);
    assign rp      = wp - n_len[LOG2_MAX-1:0];

    assign x_ext  = PW'(in_data);
    assign c_ext  = PW'(coef_c);
    assign s_ext  = PW'(coef_s);
    assign prod_i = x_ext * c_ext;
    assign prod_q = x_ext * s_ext;
    assign old_i  = is_full ? mem_i[rp] : '0;
    assign old_q  = is_full ? mem_q[rp] : '0;

    // Delay line write: store the newest products.
    always_ff @(posedge clk) begin
        if (in_valid) begin
            mem_i[wp] <= prod_i;
            mem_q[wp] <= prod_q;
        end
    end

    // Running sums, write pointer, fill level and result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp        <= '0;
            fill      <= '0;
            acc_i     <= '0;
            acc_q     <= '0;
            out_valid <= 1'b0;
            out_full  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                acc_i    <= acc_i + AW'(prod_i) - AW'(old_i);
                acc_q    <= acc_q + AW'(prod_q) - AW'(old_q);
                wp       <= wp + 1'b1;
                out_full <= is_full || ((fill + 1'b1) == n_len);
                if (!is_full) fill <= fill + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sdft_step_detect.sv
// Step detector: squares the change between consecutive full-window
// results, compares it with the limit and pulses the flag one cycle after
// the offending result. Keeps a saturating event counter.
module sdft_step_detect #(
    parameter int AW    = 30,
    parameter int CNT_W = 16,
    localparam int MW   = 2 * AW + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 res_valid,
    input  logic                 res_full,
    input  logic signed [AW-1:0] res_i,
    input  logic signed [AW-1:0] res_q,
    input  logic [MW-1:0]        thresh,
    output logic                 flag,
    output logic [CNT_W-1:0]     count
);
    logic signed [AW-1:0] prev_i, prev_q;
    logic                 prev_full;
    logic signed [AW:0]   d_i, d_q;
    logic signed [MW-1:0] sq_i, sq_q;
    logic [MW-1:0]        mag;
    logic                 hit;

    assign d_i  = (AW+1)'(res_i) - (AW+1)'(prev_i);
    assign d_q  = (AW+1)'(res_q) - (AW+1)'(prev_q);
    assign sq_i = MW'(d_i) * MW'(d_i);
    assign sq_q = MW'(d_q) * MW'(d_q);
    assign mag  = sq_i + sq_q;
    assign hit  = res_valid && res_full && prev_full && (mag > thresh);

    // Previous result, flag pulse and saturating counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_i    <= '0;
            prev_q    <= '0;
            prev_full <= 1'b0;
            flag      <= 1'b0;
            count     <= '0;
        end else begin
            flag <= hit;
            if (hit && (count != '1)) count <= count + 1'b1;
            if (res_valid) begin
                prev_i    <= res_i;
                prev_q    <= res_q;
                prev_full <= res_full;
            end
        end
    end
endmodule

// File: rtl/sdft_glitch_detector.sv
// Top level: coefficient source, mixer with moving sums, step detector.
// Assumes cfg_log2n is within 2..LOG2_MAX and changes only during reset.
module sdft_glitch_detector #(
    parameter int  LOG2_MAX = 6,
    parameter int  DW       = 12,
    parameter int  CW       = 12,
    parameter int  CNT_W    = 16,
    localparam int LW       = $clog2(LOG2_MAX + 1),
    localparam int AW       = DW + CW + LOG2_MAX,
    localparam int MW       = 2 * AW + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_sample,
    input  logic [LW-1:0]        cfg_log2n,
    input  logic [MW-1:0]        cfg_thresh,
    output logic                 out_valid,
    output logic signed [AW-1:0] out_i,
    output logic signed [AW-1:0] out_q,
    output logic                 glitch,
    output logic [CNT_W-1:0]     glitch_count
);
    logic signed [CW-1:0] coef_c, coef_s;
    logic                 win_full;

    sdft_twiddle #(.LOG2_MAX(LOG2_MAX), .CW(CW), .LW(LW)) i_twiddle (
        .clk(clk), .rst_n(rst_n), .step_en(in_valid), .log2n(cfg_log2n),
        .coef_c(coef_c), .coef_s(coef_s)
    );

    sdft_window #(.LOG2_MAX(LOG2_MAX), .DW(DW), .CW(CW), .LW(LW)) i_window (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_sample),
        .coef_c(coef_c), .coef_s(coef_s), .log2n(cfg_log2n),
        .acc_i(out_i), .acc_q(out_q), .out_valid(out_valid), .out_full(win_full)
    );

    sdft_step_detect #(.AW(AW), .CNT_W(CNT_W)) i_step (
        .clk(clk), .rst_n(rst_n), .res_valid(out_valid), .res_full(win_full),
        .res_i(out_i), .res_q(out_q), .thresh(cfg_thresh),
        .flag(glitch), .count(glitch_count)
    );
endmodule

// File: rtl/sdft_checker.sv
// Protocol checks on the monitor's ports; attached to every instance of
// the top by the bind at the end of this file.
module sdft_checker #(
    parameter int LOG2_MAX = 6,
    parameter int LW       = 3,
    parameter int AW       = 30,
    parameter int CNT_W    = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [LW-1:0]        cfg_log2n,
    input logic                 out_valid,
    input logic signed [AW-1:0] out_i,
    input logic signed [AW-1:0] out_q,
    input logic                 glitch,
    input logic [CNT_W-1:0]     glitch_count
);
    localparam int SW = LOG2_MAX + 2;
    logic [SW-1:0]     seen;
    logic [LOG2_MAX:0] n_len;

    assign n_len = (LOG2_MAX+1)'(1) << cfg_log2n;

    // Accepted samples since reset, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                     seen <= '0;
        else if (in_valid && !seen[SW-1]) seen <= seen + 1'b1;
    end

    assert_valid_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_i) && $stable(out_q)));
    assert_fill_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        glitch |-> (seen > SW'(n_len)));
    assert_flag_after_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        glitch |-> $past(out_valid));
    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        glitch |-> ((glitch_count == $past(glitch_count) + 1'b1) ||
                    ($past(glitch_count) == '1 && glitch_count == '1)));
    assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !glitch |-> $stable(glitch_count));
    assert_reset_state_R9: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !glitch && glitch_count == '0 &&
                    out_i == '0 && out_q == '0));
endmodule

bind sdft_glitch_detector sdft_checker #(
    .LOG2_MAX(LOG2_MAX), .LW(LW), .AW(AW), .CNT_W(CNT_W)
) i_sdft_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cfg_log2n(cfg_log2n),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
    .glitch(glitch), .glitch_count(glitch_count)
);

// File: tb/test_sdft_glitch_detector.sv
`timescale 1ns/1ps
// Bench: behavioural reference (queues of products, 64-bit sums) compared
// with every output on every clock, plus scenario-level checks.
module test_sdft_glitch_detector;
    localparam int MAXL = 6, DW = 12, CW = 12, CNT_W = 4;
    localparam int LW = 3, AW = DW + CW + MAXL, MW = 2 * AW + 3;
    localparam real PI2 = 6.283185307179586;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_sample = '0;
    logic [LW-1:0]        cfg_log2n = 3'd2;
    logic [MW-1:0]        cfg_thresh = '0;
    logic                 out_valid, glitch;
    logic signed [AW-1:0] out_i, out_q;
    logic [CNT_W-1:0]     glitch_count;

    sdft_glitch_detector #(.LOG2_MAX(MAXL), .DW(DW), .CW(CW), .CNT_W(CNT_W))
        i_sdft_glitch_detector (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .cfg_log2n(cfg_log2n), .cfg_thresh(cfg_thresh), .out_valid(out_valid),
        .out_i(out_i), .out_q(out_q), .glitch(glitch), .glitch_count(glitch_count));

    always #2.5 clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // Reference model state
    longint q_i[$], q_q[$];
    longint m_i, m_q, p_i, p_q;
    bit     m_valid, m_full, p_full, m_glitch;
    int     m_cnt, n_acc, win;
    longint thr;

    function automatic int rnd(input real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(0.5 - v);
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R3 out_valid", longint'(out_valid), longint'(m_valid));
        chk("R3 out_i", longint'(out_i), m_i);
        chk("R3 out_q", longint'(out_q), m_q);
        chk("R6 glitch", longint'(glitch), longint'(m_glitch));
        chk("R8 glitch_count", longint'(glitch_count), longint'(m_cnt));
    endtask

    // One clock: drive at negedge, advance model, check at next negedge.
    task automatic step(input bit v, input int x);
        bit ng;
        longint si, sq;
        int k;
        in_valid  = v;
        in_sample = DW'(x);
        ng = m_valid && m_full && p_full &&
             ((m_i - p_i) * (m_i - p_i) + (m_q - p_q) * (m_q - p_q) > thr);
        if (ng && m_cnt != (1 << CNT_W) - 1) m_cnt++;
        if (m_valid) begin p_i = m_i; p_q = m_q; p_full = m_full; end
        m_glitch = ng;
        m_valid  = v;
        if (v) begin
            k = (n_acc % win) * (64 / win);                       // R1 phase
            q_i.push_back(longint'(x) * rnd(2047.0 * $cos(PI2 * k / 64.0)));
            q_q.push_back(longint'(x) * rnd(-2047.0 * $sin(PI2 * k / 64.0)));
            if (q_i.size() > win) begin void'(q_i.pop_front()); void'(q_q.pop_front()); end
            si = 0; sq = 0;
            foreach (q_i[j]) begin si += q_i[j]; sq += q_q[j]; end
            m_i = si; m_q = sq;
            m_full = (q_i.size() == win);
            n_acc++;
        end
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset(input int l2, input longint th);
        rst_n = 1'b0; in_valid = 1'b0;
        cfg_log2n = LW'(l2); cfg_thresh = MW'(th);
        repeat (3) @(posedge clk);
        @(negedge clk);
        q_i.delete(); q_q.delete();
        m_i = 0; m_q = 0; p_i = 0; p_q = 0;
        m_valid = 0; m_full = 0; p_full = 0; m_glitch = 0; m_cnt = 0; n_acc = 0;
        win = 1 << l2; thr = th;
        compare_all();                                            // R9 reset state
        rst_n = 1'b1;
    endtask

    int base;
    real ph;

    initial begin
        // Exact tone at N=4, zero limit, with idle gaps (R1, R3, R4, R5, R7)
        do_reset(2, 0);
        for (int n = 0; n < 48; n++) begin
            step(1'b1, rnd(1500.0 * $cos(PI2 * n / 4.0 + 0.3)));
            if (n % 7 == 3) begin step(1'b0, 999); step(1'b0, -5); end
        end
        chk("R7 exact tone no flag", longint'(glitch_count), 0);
        chk("R5 fill quiet", longint'(glitch_count), 0);

        // Dropped then repeated sample at N=4 (R10, R6)
        do_reset(2, 64'd10000000000);
        for (int n = 0; n < 20; n++) step(1'b1, rnd(1500.0 * $cos(PI2 * n / 4.0)));
        for (int n = 21; n < 40; n++) step(1'b1, rnd(1500.0 * $cos(PI2 * n / 4.0)));
        repeat (2) step(1'b0, 0);
        base = int'(glitch_count);
        chk("R10 drop flagged", longint'(base > 0), 1);
        for (int n = 39; n < 60; n++) step(1'b1, rnd(1500.0 * $cos(PI2 * n / 4.0)));
        repeat (2) step(1'b0, 0);
        chk("R10 repeat flagged", longint'(int'(glitch_count) > base), 1);

        // Drifting tone at N=64 stays quiet, then a drop is caught (R10, R2)
        do_reset(6, 64'd2500000000);
        ph = 0.0;
        for (int n = 0; n < 600; n++) begin
            step(1'b1, rnd(1500.0 * $cos(ph)));
            ph += PI2 * (1.0 / 64.0 + 1.0e-5);
        end
        chk("R10 drift quiet", longint'(glitch_count), 0);
        ph += PI2 * (1.0 / 64.0 + 1.0e-5);
        for (int n = 0; n < 100; n++) begin
            step(1'b1, rnd(1500.0 * $cos(ph)));
            ph += PI2 * (1.0 / 64.0 + 1.0e-5);
        end
        repeat (2) step(1'b0, 0);
        chk("R10 drop at N=64 flagged", longint'(glitch_count > 0), 1);

        // Repeated drops at N=8, zero limit: counter saturates (R8)
        do_reset(3, 0);
        base = 0;
        for (int n = 0; n < 300; n++) begin
            if (n % 10 == 9) base++;
            step(1'b1, rnd(1500.0 * $cos(PI2 * (n + base) / 8.0)));
        end
        repeat (2) step(1'b0, 0);
        chk("R8 saturated", longint'(glitch_count), (1 << CNT_W) - 1);

        // Mid-run reset clears everything (R9)
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R9 count cleared", longint'(glitch_count), 0);
        chk("R9 out_i cleared", longint'(out_i), 0);
        chk("R9 out_valid low", longint'(out_valid), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule